// File: doc/BRIEF.md
# Auto-Increment Word Program Sequencer

This block is the control core of a serial-flash slave for the mode in which consecutive two-byte words are programmed without resending an address. A byte-level receiver delivers framed bytes together with a flag that marks the opcode byte. It also delivers a strobe when chip select rises, and a second flag when that rise cut a byte short. The sequencer decodes each finished frame, issues one word write to the array port, and models the self-timed program with a busy countdown. It also owns the write-enable latch and the mode status bit.

The first word of a run carries a three-byte address. Later words carry only two data bytes, and the address advances by two for each one. If the hardware end-of-write option was switched on beforehand, the serial output shows an active-low busy flag while chip select is low during the run. An external flag reports whether the start address is protected. A limit input gives the highest unprotected address, which ends the run.

Top module: `aai_word_seq`

## Requirements
- R1: Opcode 06h sets the write-enable latch (`wel`). A start frame received while `wel` is 0 produces no write and leaves `aai_on` at 0.
- R2: A start frame is opcode ADh, three address bytes sent MSB first, then data bytes D0 and D1. When `wel` is set, the block is idle and `prot_hit` is low, the chip-select rise triggers one `wr_req` pulse in the next cycle. That pulse carries `wr_addr` equal to the received address with bit 0 cleared, `wr_data[7:0]` = D0 (A0=0) and `wr_data[15:8]` = D1 (A0=1), and it sets `aai_on`.
- R3: While `aai_on` is set, a frame of ADh plus two data bytes writes to the previous word address plus 2.
- R4: `busy` rises together with `wr_req` and stays high for exactly PROG_CYC clock cycles.
- R5: An ADh frame that completes while `busy` is high produces no write, and the next accepted word still goes to the previous address plus 2.
- R6: While `aai_on` is set, opcodes other than ADh, 04h and 05h change no state. In particular, 70h and 80h leave the hardware-detect enable unchanged.
- R7: Opcode 04h clears both `wel` and `aai_on`, and a running busy countdown is not stopped.
- R8: Opcode 70h, given outside the mode, sets `hw_eow`, and 80h outside the mode clears it. With `hw_eow` and `aai_on` set and `cs_n` low, `so_oe` is 1 in the same cycle and `so_val` is the inverse of `busy`. With `cs_n` high, `so_oe` is 0.
- R9: When a written word's odd-byte address reaches or passes `limit_addr`, `aai_on` and `wel` clear once its busy countdown ends.
- R10: A start frame with `prot_hit` high at the chip-select rise produces no write and leaves `aai_on` at 0.
- R11: A frame ended with `cs_abort`, or one with the wrong number of bytes for its opcode, is discarded with no write and no state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip-select level, low while selected |
| byte_vld | input | 1 | A received byte is present |
| byte_first | input | 1 | Present byte is the opcode of a new frame |
| byte_in | input | 8 | Received byte |
| cs_rise | input | 1 | One-cycle strobe: chip select went high |
| cs_abort | input | 1 | With cs_rise: a byte was left incomplete |
| prot_hit | input | 1 | Start address lies in a protected area |
| limit_addr | input | 24 | Highest unprotected byte address |
| wr_req | output | 1 | One-cycle word write request |
| wr_addr | output | 24 | Even byte address of the word |
| wr_data | output | 16 | High byte to odd address, low byte to even |
| busy | output | 1 | Program in progress |
| wel | output | 1 | Write-enable latch |
| aai_on | output | 1 | Auto-increment mode active |
| hw_eow | output | 1 | Serial output assigned to ready/busy |
| so_oe | output | 1 | Serial output enable |
| so_val | output | 1 | Serial output value, 1 = ready |

## Verification
A disable command (04h) can land while a program countdown is running. In that cycle the latch and the mode bit clear while the busy counter keeps counting. The bench provokes this by sending 04h directly after a continuation word, with `busy` still high. It then checks that `wel` and `aai_on` read 0 while `busy` reads 1, and that the busy run still lasts its full length. The same overlap arises when a run's limit is reached: clearing only starts after the countdown expires. This is judged by reading `aai_on` before and after the final busy cycle.

// File: rtl/aai_pkg.sv
package aai_pkg;

    localparam logic [7:0] OPC_WREN  = 8'h06;
    localparam logic [7:0] OPC_WRDI  = 8'h04;
    localparam logic [7:0] OPC_RDSR  = 8'h05;
    localparam logic [7:0] OPC_WORD  = 8'hAD;
    localparam logic [7:0] OPC_HW_ON = 8'h70;
    localparam logic [7:0] OPC_HW_OF = 8'h80;

    typedef enum logic [2:0] {
        K_NONE,
        K_WREN,
        K_WRDI,
        K_RDSR,
        K_WORD,
        K_HWON,
        K_HWOFF
    } cmd_e;

    typedef struct packed {
        logic [7:0] hi;
        logic [7:0] lo;
    } word_t;

    function automatic cmd_e op_kind(input logic [7:0] op);
        case (op)
            OPC_WREN:  return K_WREN;
            OPC_WRDI:  return K_WRDI;
            OPC_RDSR:  return K_RDSR;
            OPC_WORD:  return K_WORD;
            OPC_HW_ON: return K_HWON;
            OPC_HW_OF: return K_HWOFF;
            default:   return K_NONE;
        endcase
    endfunction

endpackage

// File: rtl/aai_frame_rx.sv
module aai_frame_rx #(
    parameter int NB = 5,
    parameter int CW = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            byte_vld,
    input  logic            byte_first,
    input  logic [7:0]      byte_in,
    input  logic            cs_rise,
    output logic [7:0]      op,
    output logic            has_op,
    output logic [CW-1:0]   nbytes,
    output logic [8*NB-1:0] payload
);
    localparam logic [CW-1:0] SAT = CW'(NB + 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            op      <= '0;
            has_op  <= 1'b0;
            nbytes  <= '0;
            payload <= '0;
        end else if (byte_vld && byte_first) begin
            op      <= byte_in;
            has_op  <= 1'b1;
            nbytes  <= '0;
        end else if (byte_vld) begin
            payload <= {payload[8*NB-9:0], byte_in};
            if (nbytes != SAT)
                nbytes <= nbytes + CW'(1);
        end else if (cs_rise) begin
            has_op  <= 1'b0;
        end
    end
endmodule

// File: rtl/aai_prog_timer.sv
module aai_prog_timer #(
    parameter int PROG_CYC = 2000
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic busy
);
    localparam int TW = $clog2(PROG_CYC + 1);
    logic [TW-1:0] left;

    always_ff @(posedge clk) begin
        if (rst)
            left <= '0;
        else if (load)
            left <= TW'(PROG_CYC);
        else if (left != '0)
            left <= left - TW'(1);
    end

    assign busy = (left != '0);
endmodule

// File: rtl/aai_word_seq.sv
module aai_word_seq
    import aai_pkg::*;
#(
    parameter int ADDR_BYTES = 3,
    parameter int PROG_CYC   = 2000
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      cs_n,
    input  logic                      byte_vld,
    input  logic                      byte_first,
    input  logic [7:0]                byte_in,
    input  logic                      cs_rise,
    input  logic                      cs_abort,
    input  logic                      prot_hit,
    input  logic [8*ADDR_BYTES-1:0]   limit_addr,
    output logic                      wr_req,
    output logic [8*ADDR_BYTES-1:0]   wr_addr,
    output logic [15:0]               wr_data,
    output logic                      busy,
    output logic                      wel,
    output logic                      aai_on,
    output logic                      hw_eow,
    output logic                      so_oe,
    output logic                      so_val
);
    localparam int AW = 8 * ADDR_BYTES;
    localparam int NB = ADDR_BYTES + 2;
    localparam int CW = $clog2(NB + 2);
    localparam logic [CW-1:0] N_START = CW'(NB);
    localparam logic [CW-1:0] N_CONT  = CW'(2);

    logic [7:0]      op;
    logic            has_op;
    logic [CW-1:0]   nbytes;
    logic [8*NB-1:0] payload;

    aai_frame_rx #(.NB(NB), .CW(CW)) u_rx (
        .clk(clk), .rst(rst), .byte_vld(byte_vld), .byte_first(byte_first),
        .byte_in(byte_in), .cs_rise(cs_rise), .op(op), .has_op(has_op),
        .nbytes(nbytes), .payload(payload)
    );

    logic    exec, start_ok, cont_ok, issue, simple;
    cmd_e    kind;
    word_t   wd;
    logic [AW-1:0] rx_addr, base, next_addr;
    logic          end_pend;

    assign kind     = op_kind(op);
    assign exec     = cs_rise && !cs_abort && has_op;
    assign rx_addr  = payload[8*NB-1:16];
    assign wd.lo    = payload[15:8];
    assign wd.hi    = payload[7:0];
    assign start_ok = (kind == K_WORD) && !aai_on && (nbytes == N_START)
                      && wel && !busy && !prot_hit;
    assign cont_ok  = (kind == K_WORD) && aai_on && (nbytes == N_CONT) && !busy;
    assign issue    = exec && (start_ok || cont_ok);
    assign simple   = exec && (nbytes == '0);
    assign base     = start_ok ? {rx_addr[AW-1:1], 1'b0} : next_addr;

    aai_prog_timer #(.PROG_CYC(PROG_CYC)) u_tmr (
        .clk(clk), .rst(rst), .load(issue), .busy(busy)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_req    <= 1'b0;
            wr_addr   <= '0;
            wr_data   <= '0;
            next_addr <= '0;
            wel       <= 1'b0;
            aai_on    <= 1'b0;
            hw_eow    <= 1'b0;
            end_pend  <= 1'b0;
        end else begin
            wr_req <= issue;
            if (issue) begin
                wr_addr   <= base;
                wr_data   <= wd;
                next_addr <= base + AW'(2);
                aai_on    <= 1'b1;
                end_pend  <= ({base[AW-1:1], 1'b1} >= limit_addr);
            end else if (simple) begin
                case (kind)
                    K_WREN:  if (!aai_on) wel <= 1'b1;
                    K_WRDI:  begin
                        wel      <= 1'b0;
                        aai_on   <= 1'b0;
                        end_pend <= 1'b0;
                    end
                    K_HWON:  if (!aai_on) hw_eow <= 1'b1;
                    K_HWOFF: if (!aai_on) hw_eow <= 1'b0;
                    default: ;
                endcase
            end else if (end_pend && !busy) begin
                aai_on   <= 1'b0;
                wel      <= 1'b0;
                end_pend <= 1'b0;
            end
        end
    end

    assign so_oe  = hw_eow && aai_on && !cs_n;
    assign so_val = !busy;
endmodule

// File: rtl/aai_seq_chk.sv
module aai_seq_chk #(
    parameter int AW       = 24,
    parameter int PROG_CYC = 2000
) (
    input logic          clk,
    input logic          rst,
    input logic          cs_n,
    input logic          wr_req,
    input logic [AW-1:0] wr_addr,
    input logic          busy,
    input logic          wel,
    input logic          aai_on,
    input logic          so_oe
);
    localparam int TW = $clog2(PROG_CYC + 2);
    logic [TW-1:0] run;

    always_ff @(posedge clk) begin
        if (rst)       run <= '0;
        else if (busy) run <= run + TW'(1);
        else           run <= '0;
    end

    a_r1_req_needs_wel: assert property (@(posedge clk) disable iff (rst)
        wr_req |-> $past(wel));
    a_r4_busy_with_req: assert property (@(posedge clk) disable iff (rst)
        wr_req |-> busy);
    a_r4_busy_len: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> run == TW'(PROG_CYC));
    a_r5_no_req_while_busy: assert property (@(posedge clk) disable iff (rst)
        wr_req |-> !$past(busy));
    a_r3_addr_step: assert property (@(posedge clk) disable iff (rst)
        (wr_req && $past(aai_on)) |-> wr_addr == $past(wr_addr) + AW'(2));
    a_r8_so_released: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !so_oe);
endmodule

bind aai_word_seq aai_seq_chk #(.AW(AW), .PROG_CYC(PROG_CYC)) u_chk (
    .clk(clk), .rst(rst), .cs_n(cs_n), .wr_req(wr_req), .wr_addr(wr_addr),
    .busy(busy), .wel(wel), .aai_on(aai_on), .so_oe(so_oe)
);

// File: tb/sim_aai_word_seq.sv
`timescale 1ns/1ps
module sim_aai_word_seq;
    localparam int PC = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1, byte_vld = 1'b0, byte_first = 1'b0;
    logic [7:0] byte_in = '0;
    logic cs_rise = 1'b0, cs_abort = 1'b0, prot_hit = 1'b0;
    logic [23:0] limit_addr = 24'hFFFFFF;
    logic wr_req, busy, wel, aai_on, hw_eow, so_oe, so_val;
    logic [23:0] wr_addr;
    logic [15:0] wr_data;

    aai_word_seq #(.ADDR_BYTES(3), .PROG_CYC(PC)) u0 (
        .clk(clk), .rst(rst), .cs_n(cs_n), .byte_vld(byte_vld),
        .byte_first(byte_first), .byte_in(byte_in), .cs_rise(cs_rise),
        .cs_abort(cs_abort), .prot_hit(prot_hit), .limit_addr(limit_addr),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .busy(busy),
        .wel(wel), .aai_on(aai_on), .hw_eow(hw_eow), .so_oe(so_oe), .so_val(so_val)
    );

    always #2.5 clk = ~clk;

    int n_run = 0, n_fail = 0;
    int wr_cnt = 0, brun = 0, last_run = 0;
    logic [23:0] last_addr = '0;
    logic [15:0] last_data = '0;

    always @(negedge clk) begin
        if (wr_req) begin
            wr_cnt++;
            last_addr = wr_addr;
            last_data = wr_data;
        end
        if (busy) brun++;
        else if (brun != 0) begin
            last_run = brun;
            brun = 0;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic frame(input int n, input logic [47:0] v, input bit abort);
        @(negedge clk);
        cs_n = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            byte_vld = 1'b1;
            byte_first = (i == 0);
            byte_in = v[47-8*i -: 8];
        end
        @(negedge clk);
        byte_vld = 1'b0;
        byte_first = 1'b0;
        cs_n = 1'b1;
        cs_rise = 1'b1;
        cs_abort = abort;
        @(negedge clk);
        cs_rise = 1'b0;
        cs_abort = 1'b0;
        @(negedge clk);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 200 && busy; i++) @(negedge clk);
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk(!wel && !aai_on && !busy && !hw_eow && !so_oe && !wr_req,
            "R1", "reset state", {wel, aai_on, busy, hw_eow, so_oe}, 0);
    endtask

    task automatic t_no_wel();
        int w0 = wr_cnt;
        frame(6, 48'hAD_00_10_00_11_22, 0);
        chk(wr_cnt == w0 && !aai_on, "R1", "start without wel", wr_cnt - w0, 0);
    endtask

    task automatic t_start();
        frame(1, 48'h06_00_00_00_00_00, 0);
        chk(wel == 1'b1, "R1", "wel after 06h", wel, 1);
        frame(6, 48'hAD_01_23_45_AA_55, 0);
        chk(last_addr == 24'h012344, "R2", "start address", last_addr, 24'h012344);
        chk(last_data == 16'h55AA, "R2", "start data", last_data, 16'h55AA);
        chk(aai_on && busy, "R2", "mode and busy", {aai_on, busy}, 3);
    endtask

    task automatic t_busy_drop();
        int w0 = wr_cnt;
        frame(3, 48'hAD_77_66_00_00_00, 0);
        chk(wr_cnt == w0, "R5", "word while busy", wr_cnt - w0, 0);
        wait_idle();
        chk(last_run == PC, "R4", "busy length", last_run, PC);
        frame(3, 48'hAD_33_44_00_00_00, 0);
        chk(last_addr == 24'h012346, "R3", "next word address", last_addr, 24'h012346);
        chk(last_data == 16'h4433, "R3", "next word data", last_data, 16'h4433);
        wait_idle();
    endtask

    task automatic t_illegal();
        int w0;
        frame(1, 48'h70_00_00_00_00_00, 0);
        chk(!hw_eow, "R6", "70h inside mode", hw_eow, 0);
        w0 = wr_cnt;
        frame(3, 48'hAD_01_02_00_00_00, 1);
        chk(wr_cnt == w0, "R11", "aborted word", wr_cnt - w0, 0);
        frame(2, 48'hAD_01_00_00_00_00, 0);
        chk(wr_cnt == w0, "R11", "short word", wr_cnt - w0, 0);
        frame(3, 48'hAD_05_06_00_00_00, 0);
        chk(last_addr == 24'h012348, "R11", "state kept", last_addr, 24'h012348);
    endtask

    task automatic t_wrdi();
        frame(1, 48'h04_00_00_00_00_00, 0);
        chk(!wel && !aai_on, "R7", "wrdi clears", {wel, aai_on}, 0);
        chk(busy == 1'b1, "R7", "busy kept", busy, 1);
        wait_idle();
        chk(last_run == PC, "R7", "busy full after wrdi", last_run, PC);
    endtask

    task automatic t_prot();
        int w0;
        frame(1, 48'h06_00_00_00_00_00, 0);
        prot_hit = 1'b1;
        w0 = wr_cnt;
        frame(6, 48'hAD_05_00_00_12_34, 0);
        prot_hit = 1'b0;
        chk(wr_cnt == w0 && !aai_on, "R10", "protected start", wr_cnt - w0, 0);
    endtask

    task automatic t_hw();
        frame(1, 48'h70_00_00_00_00_00, 0);
        chk(hw_eow == 1'b1, "R8", "70h sets", hw_eow, 1);
        frame(6, 48'hAD_00_01_00_11_22, 0);
        chk(last_addr == 24'h000100, "R2", "hw start address", last_addr, 24'h000100);
        @(negedge clk);
        cs_n = 1'b0;
        #1;
        chk(so_oe && !so_val, "R8", "so shows busy", {so_oe, so_val}, 2);
        cs_n = 1'b1;
        frame(1, 48'h80_00_00_00_00_00, 0);
        chk(hw_eow == 1'b1, "R6", "80h inside mode", hw_eow, 1);
        wait_idle();
        cs_n = 1'b0;
        #1;
        chk(so_oe && so_val, "R8", "so shows ready", {so_oe, so_val}, 3);
        cs_n = 1'b1;
        #1;
        chk(!so_oe, "R8", "so released", so_oe, 0);
        frame(1, 48'h04_00_00_00_00_00, 0);
        frame(1, 48'h80_00_00_00_00_00, 0);
        chk(!hw_eow, "R8", "80h clears", hw_eow, 0);
    endtask

    task automatic t_limit();
        int w0;
        limit_addr = 24'h000203;
        frame(1, 48'h06_00_00_00_00_00, 0);
        frame(6, 48'hAD_00_02_00_01_02, 0);
        wait_idle();
        chk(aai_on == 1'b1, "R9", "below limit", aai_on, 1);
        frame(3, 48'hAD_03_04_00_00_00, 0);
        chk(last_addr == 24'h000202, "R9", "last word", last_addr, 24'h000202);
        chk(aai_on == 1'b1, "R9", "mode during final busy", aai_on, 1);
        wait_idle();
        chk(!aai_on && !wel, "R9", "limit ends mode", {aai_on, wel}, 0);
        w0 = wr_cnt;
        frame(3, 48'hAD_09_09_00_00_00, 0);
        chk(wr_cnt == w0, "R9", "no word past limit", wr_cnt - w0, 0);
        limit_addr = 24'hFFFFFF;
    endtask

    initial begin
        #(5.0 * 100000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_no_wel();
        t_start();
        t_busy_drop();
        t_illegal();
        t_wrdi();
        t_prot();
        t_hw();
        t_limit();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule